// File: doc/BRIEF.md
# Oversampled UART Receive Path with Buffered Data-Ready Interrupt

This block takes the asynchronous serial input of a UART and turns it into bytes. A two-flop synchronizer feeds a bit-level state machine that runs on a one-cycle oversample tick from an external baud generator. A select input sets the oversampling factor to 16 or 13 ticks per bit. The machine confirms the start bit at mid-bit, samples each following bit at its centre, and shifts the bits in least significant bit first. The word length and parity settings come from line-control inputs.

Each finished character goes into a receive buffer. With the mode input low, the buffer is a single holding register. With the mode input high, it is a 16-entry first-in first-out queue. The oldest character is presented on a 32-bit read port, and a one-cycle read strobe removes it. A data-ready interrupt follows the buffer fill level. In holding-register mode it is set by one character and cleared by reading it. In queue mode it compares the fill level against a selectable threshold. Sticky error flags report overrun, framing and parity errors.

Top module: `uart_rx_buf`

## Requirements
- R1: A start bit is accepted only if the synchronized line is still low on the 8th tick (16x mode) or the 6th tick (13x mode), counting the first tick that sees it low as tick 1. A low pulse shorter than that stores nothing, and the receiver returns to idle ready for the next frame.
- R2: Data bits are sampled once per bit period at the centre and shifted in LSB first. `word_len` 00/01/10/11 selects 5/6/7/8 data bits, and the character is right-aligned with zeros above.
- R3: With `os13_sel`=0 a bit lasts 16 `os_tick` pulses; with `os13_sel`=1 it lasts 13.
- R4: With `par_en`=1 one parity bit follows the data. `par_even`=1 expects even parity and `par_even`=0 expects odd parity. A mismatch sets the sticky `par_err`, and the character is still stored.
- R5: A stop bit sampled low sets the sticky `frm_err`, and the character is still stored.
- R6: With `fifo_en`=0 the buffer holds one character. With `dr_ie`=1, `irq` goes high once a character is stored and low after the strobe that reads it.
- R7: With `fifo_en`=1 the buffer holds up to 16 characters and returns them in arrival order.
- R8: With `fifo_en`=1 and `dr_ie`=1, `irq` is high exactly while the fill level is at least the threshold. `trig_sel` 00/01/10/11 selects 1/4/8/14 entries.
- R9: A character completed while the buffer is full (16 in queue mode, 1 in holding mode) is discarded, and the sticky `ovr_err` is set. Buffer contents are unchanged.
- R10: `rd_data[7:0]` shows the oldest stored character and `rd_data[31:8]` is always zero. An empty buffer reads as zero, and a strobe on an empty buffer changes nothing.
- R11: With `dr_ie`=0, `irq` stays low whatever the fill level. Raising `dr_ie` with data above the threshold raises `irq`.
- R12: After reset the buffer is empty, `irq` is low and all error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| os_tick | input | 1 | One-cycle oversample enable from the baud generator |
| os13_sel | input | 1 | 1 selects 13 ticks per bit, 0 selects 16 |
| fifo_en | input | 1 | 1 selects the 16-entry queue, 0 the holding register |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| trig_sel | input | 2 | Queue threshold select: 1, 4, 8 or 14 entries |
| dr_ie | input | 1 | Data-ready interrupt enable |
| rd_stb | input | 1 | Pops the oldest character |
| rd_data | output | 32 | Oldest character on bits 7:0, zero above |
| irq | output | 1 | Data-ready interrupt |
| ovr_err | output | 1 | Sticky overrun flag |
| frm_err | output | 1 | Sticky framing-error flag |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
A wrong sample phase or tick count corrupts the byte at `rd_data` within the frame, as shifted or duplicated bits. It shows one bit period after the stop bit at the latest. A wrong fill count shows at once as `irq` toggling on the wrong character. It also shows as lost or repeated bytes when the queue is drained, so the scoreboard compares every popped byte against the sent order. A wrong drop or glitch decision shows only later, as an extra or missing entry. For that reason every such case ends by draining the buffer to an empty, zero read.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  // ticks making up one bit period
  function automatic logic [4:0] bit_ticks(input logic os13);
    return os13 ? 5'd13 : 5'd16;
  endfunction

  // tick at which the start bit is confirmed
  function automatic logic [4:0] mid_ticks(input logic os13);
    return os13 ? 5'd6 : 5'd8;
  endfunction

  // number of data bits from the word-length code
  function automatic logic [3:0] char_bits(input logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction

  // queue threshold from the trigger select code
  function automatic logic [4:0] trig_entries(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // expected value of the parity bit
  function automatic logic parity_bit(input logic [CHAR_W-1:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxs,
  input  logic              os_tick,
  input  logic              os13_sel,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  output logic              char_done,
  output logic [CHAR_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr
);
  rx_state_t         state;
  logic [4:0]        sc;
  logic [3:0]        bc;
  logic [CHAR_W-1:0] shreg;
  logic              par_acc;
  logic              perr_q;

  logic [4:0] sc_nxt;
  logic [4:0] tpb;
  logic [4:0] mid;
  logic [3:0] nbits;
  // named internal events
  logic start_seen, start_ok, start_rej, bit_end, last_data;

  always_comb begin
    sc_nxt     = sc + 5'd1;
    tpb        = bit_ticks(os13_sel);
    mid        = mid_ticks(os13_sel);
    nbits      = char_bits(word_len);
    start_seen = (state == RX_IDLE) && os_tick && !rxs;
    start_ok   = (state == RX_START) && os_tick && (sc_nxt == mid) && !rxs;
    start_rej  = (state == RX_START) && os_tick && (sc_nxt == mid) && rxs;
    bit_end    = (state inside {RX_DATA, RX_PAR, RX_STOP}) && os_tick && (sc_nxt == tpb);
    last_data  = (bc + 4'd1) == nbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      sc        <= '0;
      bc        <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      perr_q    <= 1'b0;
      char_done <= 1'b0;
      char_data <= '0;
      char_perr <= 1'b0;
      char_ferr <= 1'b0;
    end else begin
      char_done <= 1'b0;
      unique case (state)
        RX_IDLE: if (start_seen) begin
          state <= RX_START;
          sc    <= 5'd1;
        end
        RX_START: if (os_tick) begin
          if (start_rej) begin
            state <= RX_IDLE;
            sc    <= '0;
          end else if (start_ok) begin
            state   <= RX_DATA;
            sc      <= '0;
            bc      <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
          end else begin
            sc <= sc_nxt;
          end
        end
        RX_DATA: if (os_tick) begin
          if (bit_end) begin
            sc                <= '0;
            shreg[bc[2:0]]    <= rxs;
            par_acc           <= par_acc ^ rxs;
            bc                <= bc + 4'd1;
            if (last_data) state <= par_en ? RX_PAR : RX_STOP;
          end else begin
            sc <= sc_nxt;
          end
        end
        RX_PAR: if (os_tick) begin
          if (bit_end) begin
            sc     <= '0;
            perr_q <= (par_acc ^ rxs) != !par_even;
            state  <= RX_STOP;
          end else begin
            sc <= sc_nxt;
          end
        end
        RX_STOP: if (os_tick) begin
          if (bit_end) begin
            sc        <= '0;
            state     <= RX_IDLE;
            char_done <= 1'b1;
            char_data <= shreg;
            char_perr <= perr_q;
            char_ferr <= !rxs;
          end else begin
            sc <= sc_nxt;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_start_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |=> (state == RX_IDLE));
  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (state == RX_DATA) && (bc == 4'd0));
  assert_tick_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc <= 5'd16));
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> !char_done);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cap;
  logic          full, push, pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    cap  = fifo_en ? CW'(DEPTH) : CW'(1);
    full = count >= cap;
    push = wr && !full;
    drop = wr && full;
    pop  = rd && (count != '0);
    head = (count != '0) ? mem[rp] : '0;
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= ptr_inc(wp);
      if (pop)  rp <= ptr_inc(rp);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rd) |=> $stable(count));
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (count == '0) && !wr) |=> (count == '0));
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RD_W    = 32,
  parameter int SYNC_N  = 2,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rxd,
  input  logic            os_tick,
  input  logic            os13_sel,
  input  logic            fifo_en,
  input  logic [1:0]      word_len,
  input  logic            par_en,
  input  logic            par_even,
  input  logic [1:0]      trig_sel,
  input  logic            dr_ie,
  input  logic            rd_stb,
  output logic [RD_W-1:0] rd_data,
  output logic            irq,
  output logic            ovr_err,
  output logic            frm_err,
  output logic            par_err
);
  logic              rxs;
  logic              char_done, char_perr, char_ferr;
  logic [CHAR_W-1:0] char_data;
  logic [CHAR_W-1:0] head;
  logic [CW-1:0]     count;
  logic              drop;
  logic [4:0]        thr;
  logic              level_hit;

  uart_rx_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
  );

  uart_rx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .rxs(rxs), .os_tick(os_tick),
    .os13_sel(os13_sel), .word_len(word_len), .par_en(par_en),
    .par_even(par_even), .char_done(char_done), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr)
  );

  uart_rx_buffer #(.DEPTH(DEPTH), .DW(CHAR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr(char_done),
    .wdata(char_data), .rd(rd_stb), .head(head), .count(count), .drop(drop)
  );

  always_comb begin
    thr       = fifo_en ? trig_entries(trig_sel) : 5'd1;
    level_hit = int'(count) >= int'(thr);
    irq       = dr_ie && level_hit;
    rd_data   = {{(RD_W - CHAR_W){1'b0}}, head};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_err <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
    end else begin
      if (drop)                   ovr_err <= 1'b1;
      if (char_done && char_ferr) frm_err <= 1'b1;
      if (char_done && char_perr) par_err <= 1'b1;
    end
  end

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> ovr_err);
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $stable(dr_ie) && $stable(fifo_en) && $stable(trig_sel)) |-> $past(char_done));
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq) && $stable(dr_ie) && $stable(fifo_en) && $stable(trig_sel)) |-> $past(rd_stb));
endmodule

// File: tb/sim_uart_rx_buf.sv
module sim_uart_rx_buf;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic os_tick = 1'b0;
  logic os13_sel = 1'b0, fifo_en = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic [1:0] word_len = 2'b11, trig_sel = 2'b00;
  logic dr_ie = 1'b1, rd_stb = 1'b0;
  logic [31:0] rd_data;
  logic irq, ovr_err, frm_err, par_err;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [$];
  string cur_req = "R2";
  event rd_ev;
  int tick_cnt = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    os_tick  <= (tick_cnt == TICK_DIV - 1);
  end

  uart_rx_buf u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .os13_sel(os13_sel),
    .fifo_en(fifo_en), .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .trig_sel(trig_sel), .dr_ie(dr_ie), .rd_stb(rd_stb), .rd_data(rd_data),
    .irq(irq), .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compare each popped byte against the scoreboard queue
  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) check(cur_req, "pop with empty scoreboard", rd_data, 32'hFFFF_FFFF);
    else check(cur_req, "popped byte", rd_data, {24'h0, exp_q.pop_front()});
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    int hold;
    hold = (os13_sel ? 13 : 16) * TICK_DIV;
    @(negedge clk); rxd = v;
    repeat (hold - 1) @(negedge clk);
  endtask

  // driver: sends a frame and pushes the expected byte
  task automatic send(input logic [7:0] d, input bit keep, input bit bad_par, input bit bad_stop);
    int nb;
    logic [7:0] m;
    logic p;
    nb = 5 + int'(word_len);
    m = 8'hFF >> (8 - nb);
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (par_en) begin
      p = par_even ? ^(d & m) : ~^(d & m);
      drive_bit(bad_par ? ~p : p);
    end
    drive_bit(bad_stop ? 1'b0 : 1'b1);
    drive_bit(1'b1);
    if (keep) exp_q.push_back(d & m);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    #1; -> rd_ev;
    @(negedge clk); rd_stb = 1'b0;
    #1;
  endtask

  task automatic raw_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    #1;
  endtask

  task automatic glitch(input int ticks);
    @(negedge clk); rxd = 1'b0;
    repeat (ticks * TICK_DIV - 1) @(negedge clk);
    rxd = 1'b1;
    repeat (40 * TICK_DIV) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    check("R12", "irq after reset", irq, 0);
    check("R12", "rd_data after reset", rd_data, 0);
    check("R12", "error flags after reset", {ovr_err, frm_err, par_err}, 0);

    // R6 holding register, R2 8-bit char
    send(8'hA5, 1, 0, 0);
    check("R6", "irq after one char", irq, 1);
    check("R10", "upper read bits", rd_data[31:8], 0);
    cur_req = "R2"; do_read();
    check("R6", "irq after read", irq, 0);

    // R2 5-bit word, upper bits dropped
    word_len = 2'b00;
    send(8'hF6, 1, 0, 0);
    do_read();
    word_len = 2'b11;

    // R4 parity odd then even then bad
    par_en = 1; par_even = 0; cur_req = "R4";
    send(8'h01, 1, 0, 0);
    check("R4", "odd parity good", par_err, 0);
    do_read();
    par_even = 1;
    send(8'h3C, 1, 0, 0);
    check("R4", "even parity good", par_err, 0);
    do_read();
    send(8'h3C, 1, 1, 0);
    check("R4", "bad parity flagged", par_err, 1);
    do_read();
    par_en = 0;

    // R5 framing
    cur_req = "R5";
    check("R5", "no framing before", frm_err, 0);
    send(8'h5A, 1, 0, 1);
    check("R5", "framing flagged", frm_err, 1);
    do_read();

    // R9 overrun in holding mode
    do_reset(); cur_req = "R9";
    send(8'h11, 1, 0, 0);
    send(8'h22, 0, 0, 0);
    check("R9", "overrun holding", ovr_err, 1);
    do_read();
    check("R10", "empty reads zero", rd_data, 0);
    raw_read();
    check("R10", "empty strobe keeps empty", rd_data, 0);
    check("R10", "irq after empty strobe", irq, 0);
    cur_req = "R10";
    send(8'h33, 1, 0, 0);
    do_read();

    // R1 glitch rejection, 16x
    glitch(3);
    check("R1", "glitch stores nothing", rd_data, 0);
    check("R1", "glitch no irq", irq, 0);
    cur_req = "R1";
    send(8'h7E, 1, 0, 0);
    do_read();

    // R3 13x mode
    os13_sel = 1; cur_req = "R3";
    send(8'hC3, 1, 0, 0);
    check("R3", "13x char ready", irq, 1);
    do_read();
    glitch(4);
    check("R1", "13x glitch stores nothing", rd_data, 0);
    send(8'h96, 1, 0, 0);
    do_read();
    os13_sel = 0;

    // R7/R8 queue with threshold 4
    do_reset(); fifo_en = 1; trig_sel = 2'b01; cur_req = "R7";
    for (int i = 0; i < 3; i++) send(8'h40 + 8'(i), 1, 0, 0);
    check("R8", "irq below 4", irq, 0);
    send(8'h43, 1, 0, 0);
    check("R8", "irq at 4", irq, 1);
    do_read();
    check("R8", "irq after drop to 3", irq, 0);
    for (int i = 0; i < 3; i++) do_read();

    // R8 threshold 14, R9 full queue
    trig_sel = 2'b11;
    for (int i = 0; i < 13; i++) send(8'h80 + 8'(i), 1, 0, 0);
    check("R8", "irq at 13 of 14", irq, 0);
    send(8'h8D, 1, 0, 0);
    check("R8", "irq at 14", irq, 1);
    send(8'h8E, 1, 0, 0);
    send(8'h8F, 1, 0, 0);
    check("R9", "no overrun at 16", ovr_err, 0);
    send(8'hEE, 0, 0, 0);
    check("R9", "overrun when full", ovr_err, 1);
    for (int i = 0; i < 16; i++) do_read();
    check("R7", "queue drained", rd_data, 0);

    // R11 interrupt enable
    trig_sel = 2'b00; dr_ie = 0; cur_req = "R11";
    send(8'h5C, 1, 0, 0);
    check("R11", "irq masked", irq, 0);
    @(negedge clk); dr_ie = 1; #1;
    check("R11", "irq unmasked", irq, 1);
    do_read();
    check("R11", "scoreboard empty", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule